// File: doc/BRIEF.md
# Complementary PWM Output Stage

This block turns three raw PWM waveforms into six output pins that form three complementary pairs: channels 0/1, 2/3 and 4/5. Each raw signal drives the even pin of its pair directly and the odd pin inverted. A per-pair dead-time inserter can hold back the rising edge of either pin, so that both pins of a pair are low for a programmed number of clocks around each transition.

The pair signals then pass through three overrides, in this order. A per-channel mask replaces a generated level with a fixed level. An active brake forces every channel to its programmed safe level. A per-channel polarity bit then selects active-high or active-low drive at the pin.

Channels 0, 2 and 4 also feed edge detectors. These set sticky flags on a selectable edge, and each flag can be enabled onto a shared interrupt line. The timebase that makes the raw signals and the logic that detects a brake lie outside this block.

Top module: `pwm_pair_stage`

## Requirements
- R1: When dead time is disabled for a pair (`dt_en_i[p]` = 0), the odd channel is the exact inverse of the even channel in the same cycle: even = raw, odd = not raw, with no delay.
- R2: Before the overrides, the two channels of a pair are never high at the same time.
- R3: When dead time is enabled for a pair with count D, each channel rises only once its raw level has stayed unchanged for D further clocks. Each channel falls in the same cycle that its raw level leaves.
- R4: A raw level that lasts D cycles or fewer, with dead time D enabled, produces no pulse on the matching channel. A level that lasts L > D cycles produces a pulse L − D cycles wide.
- R5: For each channel with `mask_en_i[c]` = 1 and no brake, the pre-polarity level is `mask_data_i[c]` (0 = low, 1 = high).
- R6: While `brake_i` = 1, each channel's pre-polarity level is `brake_lvl_i[c]`, whatever the mask holds.
- R7: The pin is the pre-polarity level XOR `pol_i[c]`. A value of 1 gives active-low drive.
- R8: Edge detector g watches the pre-polarity level of channel 2g. With `edge_type_i[g]` = 1 it sets `edge_flag_o[g]` one cycle after a rising edge. With 0 it sets the flag one cycle after a falling edge. A flag stays set until it is cleared.
- R9: `flag_clr_i[g]` = 1 clears flag g at the next clock. A selected edge in the same cycle wins, and the flag is set.
- R10: `irq_o` is high exactly when some flag g is set while `edge_ie_i[g]` = 1.
- R11: While `rst_ni` is low, all edge flags and `irq_o` are 0, whatever the raw inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_i | input | 3 | Raw PWM signal per pair |
| brake_i | input | 1 | Brake active |
| dt_count_i | input | 11 | Shared dead-time count in clocks |
| dt_en_i | input | 3 | Dead-time enable per pair |
| mask_en_i | input | 6 | Mask override enable per channel |
| mask_data_i | input | 6 | Mask override level per channel |
| brake_lvl_i | input | 6 | Level per channel while braking |
| pol_i | input | 6 | 1 = active-low pin |
| edge_type_i | input | 3 | 1 = rising, 0 = falling edge flag |
| edge_ie_i | input | 3 | Edge flag interrupt enable |
| flag_clr_i | input | 3 | Write-1 clear of edge flags |
| pin_o | output | 6 | Output pins |
| edge_flag_o | output | 3 | Edge flags of channels 0, 2, 4 |
| irq_o | output | 1 | Edge interrupt |

## Verification
The dead-time path is driven with long steady levels, with pulses exactly one cycle shorter than, equal to and longer than the count, and with a count at its maximum. Together these separate a correct rise delay from an off-by-one, from a falling-edge delay and from a glitch.

Mixed per-pair enables show that each pair honours its own bit. Masks, brake and polarity are applied both alone and in combination, which exposes a wrong priority order. The edge flags are driven with both edge types, with a clear alone and with a clear in the same cycle as an edge, and with the interrupt enables toggled.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/deadtime_pair.sv
module deadtime_pair #(
  parameter int DT_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            raw_i,
  input  logic            en_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            hi_o,
  output logic            lo_o
);
  localparam logic [DT_W-1:0] SAT = '1;

  logic            raw_q;
  logic [DT_W-1:0] run_q, run_d, eff_dt;
  logic            run_en, settled;

  // run_d: number of earlier consecutive cycles that held the current level
  always_comb begin
    if (raw_i != raw_q)    run_d = '0;
    else if (run_q == SAT) run_d = run_q;
    else                   run_d = run_q + DT_W'(1);
    eff_dt  = en_i ? dt_i : '0;
    settled = (run_d >= eff_dt);
    hi_o    = raw_i & settled;
    lo_o    = ~raw_i & settled;
    run_en  = (run_d != run_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      run_q <= '0;
    end else begin
      raw_q <= raw_i;
      if (run_en) run_q <= run_d;
    end
  end
endmodule

// File: rtl/edge_flag.sv
module edge_flag
  import pwm_stage_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sig_i,
  input  edge_sel_e sel_i,
  input  logic      clr_i,
  output logic      hit_o,
  output logic      flag_o
);
  logic sig_q, flag_q, flag_d;

  always_comb begin
    if (sel_i == EDGE_RISE) hit_o = sig_i & ~sig_q;
    else                    hit_o = ~sig_i & sig_q;
    flag_d = hit_o | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sig_q  <= sig_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pwm_pair_stage.sv
module pwm_pair_stage
  import pwm_stage_pkg::*;
#(
  parameter int N_PAIRS = 3,
  parameter int DT_W    = 11
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_PAIRS-1:0]     raw_i,
  input  logic                   brake_i,
  input  logic [DT_W-1:0]        dt_count_i,
  input  logic [N_PAIRS-1:0]     dt_en_i,
  input  logic [2*N_PAIRS-1:0]   mask_en_i,
  input  logic [2*N_PAIRS-1:0]   mask_data_i,
  input  logic [2*N_PAIRS-1:0]   brake_lvl_i,
  input  logic [2*N_PAIRS-1:0]   pol_i,
  input  logic [N_PAIRS-1:0]     edge_type_i,
  input  logic [N_PAIRS-1:0]     edge_ie_i,
  input  logic [N_PAIRS-1:0]     flag_clr_i,
  output logic [2*N_PAIRS-1:0]   pin_o,
  output logic [N_PAIRS-1:0]     edge_flag_o,
  output logic                   irq_o
);
  localparam int N_CH = 2 * N_PAIRS;

  logic [N_CH-1:0]    gen_w;
  logic [N_CH-1:0]    masked_w;
  logic [N_CH-1:0]    level_w;
  logic [N_PAIRS-1:0] edge_hit_w;

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    deadtime_pair #(.DT_W(DT_W)) u_dt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_i[p]),
      .en_i  (dt_en_i[p]),
      .dt_i  (dt_count_i),
      .hi_o  (gen_w[2*p]),
      .lo_o  (gen_w[2*p+1])
    );
  end

  // override order: mask, then brake, then polarity
  always_comb begin
    masked_w = (gen_w & ~mask_en_i) | (mask_data_i & mask_en_i);
    level_w  = brake_i ? brake_lvl_i : masked_w;
    pin_o    = level_w ^ pol_i;
  end

  for (genvar g = 0; g < N_PAIRS; g++) begin : g_edge
    edge_flag u_ef (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (level_w[2*g]),
      .sel_i (edge_sel_e'(edge_type_i[g])),
      .clr_i (flag_clr_i[g]),
      .hit_o (edge_hit_w[g]),
      .flag_o(edge_flag_o[g])
    );
  end

  assign irq_o = |(edge_flag_o & edge_ie_i);
endmodule

// File: rtl/pwm_pair_stage_chk.sv
module pwm_pair_stage_chk #(
  parameter int N_PAIRS = 3,
  parameter int DT_W    = 11
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 brake_i,
  input logic [N_PAIRS-1:0]   dt_en_i,
  input logic [2*N_PAIRS-1:0] mask_en_i,
  input logic [2*N_PAIRS-1:0] mask_data_i,
  input logic [2*N_PAIRS-1:0] brake_lvl_i,
  input logic [2*N_PAIRS-1:0] pol_i,
  input logic [N_PAIRS-1:0]   flag_clr_i,
  input logic [2*N_PAIRS-1:0] pin_o,
  input logic [N_PAIRS-1:0]   edge_flag_o,
  input logic [2*N_PAIRS-1:0] gen_w,
  input logic [N_PAIRS-1:0]   edge_hit_w
);
  for (genvar g = 0; g < N_PAIRS; g++) begin : g_a
    p_no_overlap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gen_w[2*g] && gen_w[2*g+1]));
    p_bypass_compl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dt_en_i[g] |-> (gen_w[2*g+1] == !gen_w[2*g]));
    p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_hit_w[g] |=> edge_flag_o[g]);
    p_flag_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_clr_i[g] && !edge_hit_w[g]) |=> !edge_flag_o[g]);
  end

  p_brake_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brake_i |-> (pin_o == (brake_lvl_i ^ pol_i)));

  p_mask_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brake_i |-> (((pin_o ^ pol_i) & mask_en_i) == (mask_data_i & mask_en_i)));
endmodule

bind pwm_pair_stage pwm_pair_stage_chk #(.N_PAIRS(N_PAIRS), .DT_W(DT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .brake_i    (brake_i),
  .dt_en_i    (dt_en_i),
  .mask_en_i  (mask_en_i),
  .mask_data_i(mask_data_i),
  .brake_lvl_i(brake_lvl_i),
  .pol_i      (pol_i),
  .flag_clr_i (flag_clr_i),
  .pin_o      (pin_o),
  .edge_flag_o(edge_flag_o),
  .gen_w      (gen_w),
  .edge_hit_w (edge_hit_w)
);

// File: tb/pwm_pair_stage_test.sv
`timescale 1ns/1ps
module pwm_pair_stage_test;
  localparam int NP = 3, DTW = 11, NC = 6, DT_MAX = 2047;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [NP-1:0] raw_i, dt_en_i, edge_type_i, edge_ie_i, flag_clr_i, edge_flag_o;
  logic brake_i, irq_o;
  logic [DTW-1:0] dt_count_i;
  logic [NC-1:0] mask_en_i, mask_data_i, brake_lvl_i, pol_i, pin_o;

  pwm_pair_stage #(.N_PAIRS(NP), .DT_W(DTW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw_i), .brake_i(brake_i),
    .dt_count_i(dt_count_i), .dt_en_i(dt_en_i), .mask_en_i(mask_en_i),
    .mask_data_i(mask_data_i), .brake_lvl_i(brake_lvl_i), .pol_i(pol_i),
    .edge_type_i(edge_type_i), .edge_ie_i(edge_ie_i), .flag_clr_i(flag_clr_i),
    .pin_o(pin_o), .edge_flag_o(edge_flag_o), .irq_o(irq_o)
  );

  // configuration applied at the next step
  logic [DTW-1:0] c_dt = '0;
  logic [NP-1:0]  c_dten = '0, c_etype = '0, c_eie = '0, c_clr = '0;
  logic [NC-1:0]  c_men = '0, c_mdat = '0, c_blvl = '0, c_pol = '0;
  logic           c_brk = 1'b0;

  int n_chk = 0, n_err = 0;
  // behavioural model state
  int run_len[NP];
  bit last_raw[NP], last_lvl[NP], m_flag[NP];

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [NP-1:0] raw, input string tag);
    logic [NC-1:0] gen, lvl;
    int run[NP];
    int eff, fl, irq;
    @(negedge clk);
    rst_n = 1'b1;
    raw_i = raw; dt_count_i = c_dt; dt_en_i = c_dten; mask_en_i = c_men;
    mask_data_i = c_mdat; brake_i = c_brk; brake_lvl_i = c_blvl; pol_i = c_pol;
    edge_type_i = c_etype; edge_ie_i = c_eie; flag_clr_i = c_clr;
    #1;
    for (int p = 0; p < NP; p++) begin
      if (raw[p] != last_raw[p]) run[p] = 0;
      else run[p] = (run_len[p] >= DT_MAX) ? DT_MAX : run_len[p] + 1;
      eff = c_dten[p] ? int'(c_dt) : 0;
      gen[2*p]   = raw[p] && (run[p] >= eff);
      gen[2*p+1] = !raw[p] && (run[p] >= eff);
    end
    for (int c = 0; c < NC; c++) begin
      lvl[c] = c_men[c] ? c_mdat[c] : gen[c];
      if (c_brk) lvl[c] = c_blvl[c];
    end
    fl = 0; irq = 0;
    for (int g = 0; g < NP; g++) begin
      fl = fl | (int'(m_flag[g]) << g);
      if (m_flag[g] && c_eie[g]) irq = 1;
    end
    check(tag, "pin_o", int'(pin_o), int'(lvl ^ c_pol));
    check(tag, "edge_flag_o", int'(edge_flag_o), fl);
    check(tag, "irq_o", int'(irq_o), irq);
    for (int g = 0; g < NP; g++) begin
      bit ev;
      ev = c_etype[g] ? (lvl[2*g] && !last_lvl[g]) : (!lvl[2*g] && last_lvl[g]);
      m_flag[g]   = ev || (m_flag[g] && !c_clr[g]);
      last_lvl[g] = lvl[2*g];
      last_raw[g] = raw[g];
      run_len[g]  = run[g];
    end
  endtask

  task automatic hold(input logic [NP-1:0] raw, input int n, input string tag);
    for (int i = 0; i < n; i++) step(raw, tag);
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int g = 0; g < NP; g++) begin
      run_len[g] = 0; last_raw[g] = 0; last_lvl[g] = 0; m_flag[g] = 0;
    end
    rst_n = 1'b0; raw_i = '1; brake_i = 0; dt_count_i = '0; dt_en_i = '0;
    mask_en_i = '0; mask_data_i = '0; brake_lvl_i = '0; pol_i = '0;
    edge_type_i = '1; edge_ie_i = '1; flag_clr_i = '0;
    // R11: flags and interrupt stay clear during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); raw_i = NP'(i * 5); #1;
      check("R11", "edge_flag_o", int'(edge_flag_o), 0);
      check("R11", "irq_o", int'(irq_o), 0);
    end
    // R1: no dead time, pure complements
    step(3'b000, "R1"); step(3'b111, "R1"); step(3'b101, "R1");
    step(3'b010, "R1"); step(3'b110, "R1"); step(3'b001, "R1");
    // R3: dead time 3 on all pairs, rise delayed, fall immediate
    c_dten = 3'b111; c_dt = 11'd3;
    hold(3'b111, 8, "R3"); hold(3'b000, 8, "R3");
    hold(3'b001, 6, "R3"); hold(3'b100, 6, "R3");
    // R4: short pulses vanish, longer ones shrink
    hold(3'b000, 5, "R4"); hold(3'b111, 2, "R4"); hold(3'b000, 5, "R4");
    hold(3'b111, 3, "R4"); hold(3'b000, 2, "R4"); hold(3'b111, 4, "R4");
    hold(3'b000, 5, "R4");
    c_dt = 11'd2047; hold(3'b111, 20, "R4"); hold(3'b000, 20, "R4");
    // R2: mixed per-pair enables
    c_dt = 11'd2; c_dten = 3'b010;
    step(3'b111, "R2"); step(3'b000, "R2"); step(3'b111, "R2");
    hold(3'b101, 4, "R2"); hold(3'b010, 4, "R2");
    // R5: mask override
    c_men = 6'b100101; c_mdat = 6'b000100;
    hold(3'b111, 3, "R5"); hold(3'b000, 3, "R5"); hold(3'b101, 3, "R5");
    // R6: brake wins over mask
    c_brk = 1'b1; c_blvl = 6'b110010;
    hold(3'b011, 3, "R6"); hold(3'b100, 3, "R6");
    c_men = '0; hold(3'b111, 2, "R6");
    // R7: polarity
    c_brk = 1'b0; c_pol = 6'b101101;
    hold(3'b111, 3, "R7"); hold(3'b000, 3, "R7");
    c_brk = 1'b1; step(3'b000, "R7"); c_brk = 1'b0;
    // R8: edge selection, interrupts off
    c_pol = '0; c_dten = '0; c_eie = '0; c_etype = 3'b101;
    c_clr = 3'b111; step(3'b000, "R8"); c_clr = '0;
    hold(3'b000, 2, "R8"); hold(3'b111, 2, "R8"); hold(3'b000, 2, "R8");
    c_clr = 3'b111; step(3'b000, "R8"); c_clr = '0;
    c_etype = 3'b010; hold(3'b111, 2, "R8"); hold(3'b000, 2, "R8");
    // R9: clear alone, and clear together with an edge
    c_clr = 3'b111; step(3'b000, "R9"); c_clr = '0; hold(3'b000, 2, "R9");
    c_etype = 3'b111; step(3'b000, "R9");
    c_clr = 3'b111; step(3'b111, "R9"); c_clr = '0; hold(3'b111, 2, "R9");
    c_clr = 3'b001; step(3'b111, "R9"); c_clr = '0; step(3'b111, "R9");
    // R10: interrupt gating
    c_eie = 3'b001; step(3'b111, "R10");
    c_eie = 3'b010; step(3'b111, "R10");
    c_eie = 3'b100; step(3'b111, "R10");
    c_clr = 3'b110; step(3'b111, "R10"); c_clr = '0; step(3'b111, "R10");
    c_eie = 3'b111; hold(3'b000, 2, "R10");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule